// File: doc/BRIEF.md
# Iterative sine and cosine engine

This block computes the cosine and the sine of a signed fixed-point angle with a rotation-mode CORDIC. It keeps a single set of add/subtract units and one pair of variable arithmetic shifters, and it performs one micro-rotation per clock.

A request is a one-cycle `start` pulse carrying the angle. The block then stays busy for a fixed number of cycles and presents both results together with a one-cycle `done` pulse. The starting X value is preloaded with the reciprocal of the rotation gain, so the results come out already scaled.

The angle is a signed W-bit fraction of pi: code `a` means `a*pi/2^(W-1)` radians. The results are signed W-bit values in which `2^(W-2)` stands for 1.0. Internally every register is widened by G guard bits, and the guard bits are dropped with rounding when the result is stored. The caller must keep the angle inside the convergence range of about ±1.74 rad. With the defaults (W=16) that is a code magnitude of at most 18149.

Top module: `cordic_sincos`

## Requirements
- R1: While reset is asserted and right after it, `busy` and `done` are 0 and `cos_out` and `sin_out` are 0.
- R2: A `start` sampled while `busy` is 0 is accepted, and `busy` is 1 in the following cycle.
- R3: `done` is high exactly N+1 clock edges after the edge that accepted `start` (N is the iteration count). It stays high for exactly one cycle, and `busy` is 0 whenever `done` is 1.
- R4: For any angle code inside the convergence range, `cos_out` and `sin_out` are within 4 LSB of round(cos(θ)·2^(W-2)) and round(sin(θ)·2^(W-2)), where θ = code·π/2^(W-1).
- R5: Angle code 0 gives `cos_out` within 4 LSB of 2^(W-2) (16384 by default) and `sin_out` within 4 LSB of 0.
- R6: Negative angle codes give results within 4 LSB of the true values: a negative sine and the same cosine as the mirrored positive angle.
- R7: Angles near the edge of the convergence range (±18100 with W=16, about ±1.735 rad, cosine slightly negative) still meet the 4 LSB bound.
- R8: A `start` pulse, and any value on `angle`, applied while `busy` is 1 are ignored. The running result and its latency are those of the angle that was accepted.
- R9: `cos_out` and `sin_out` change only in the cycle in which `done` is 1. They keep the previous result while idle and throughout a new computation.
- R10: A `start` applied in the cycle in which `done` is 1 is accepted. The next result follows with the normal latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request; accepted only while idle |
| angle | input | W | Signed angle, fraction of pi, sampled with an accepted start |
| busy | output | 1 | High from the cycle after an accepted start until the result is presented |
| done | output | 1 | One-cycle pulse marking new results |
| cos_out | output | W | Signed cosine, 1.0 = 2^(W-2) |
| sin_out | output | W | Signed sine, 1.0 = 2^(W-2) |

## Verification
Nearly every internal fault ends up in the two results at the `done` pulse, N+1 cycles after the request. A wrong arctangent entry, a wrong rotation sign, a wrong shift amount or a bad gain preload shows there as an error far larger than 4 LSB, on angles spread over both signs and out to the range edge. A fault in the iteration counter or the sequencer shows up sooner, as a `done` pulse at the wrong cycle, one that lasts too long, or a `busy` that overlaps it. A start that leaks in during a run corrupts both the result of the angle in flight and its latency. Outputs that move outside the `done` cycle are caught at the first idle sample.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

   localparam real PI_R = 3.14159265358979323846;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ROT  = 2'd1,
      ST_FIN  = 2'd2
   } seq_state_e;

   // arctan(2^-idx) as a fraction of pi, scaled so that pi = 2^(zw-1)
   function automatic int atan_code(input int idx, input int zw);
      real r;
      r = $atan(2.0 ** real'(-idx)) / PI_R * (2.0 ** real'(zw - 1));
      return $rtoi(r + 0.5);
   endfunction

   // product of cos(arctan(2^-k)) for k < iters, scaled so that 1.0 = 2^(xw-2)
   function automatic int inv_gain_code(input int iters, input int xw);
      real p;
      p = 1.0;
      for (int k = 0; k < iters; k++) begin
         p = p / $sqrt(1.0 + 2.0 ** real'(-2 * k));
      end
      return $rtoi(p * (2.0 ** real'(xw - 2)) + 0.5);
   endfunction

endpackage

// File: rtl/cordic_shift.sv
module cordic_shift #(
   parameter int DW    = 19,
   parameter int SW    = 4,
   parameter int STYLE = 0
) (
   input  logic signed [DW-1:0] din,
   input  logic        [SW-1:0] amt,
   output logic signed [DW-1:0] dout
);

   generate
      if (STYLE == 0) begin : g_log
         logic signed [DW-1:0] stg [SW+1];
         assign stg[0] = din;
         for (genvar s = 0; s < SW; s++) begin : g_stg
            assign stg[s+1] = amt[s] ? (stg[s] >>> (2 ** s)) : stg[s];
         end
         assign dout = stg[SW];
      end else begin : g_direct
         assign dout = din >>> amt;
      end
   endgenerate

   always_comb begin
      a_r4_shift_sign: assert (din[DW-1] == dout[DW-1] || (din == '0 && dout == '0) || (dout == '0))
         else $error("shift changed sign of operand");
   end

endmodule

// File: rtl/cordic_atan_rom.sv
module cordic_atan_rom #(
   parameter int N  = 16,
   parameter int ZW = 19,
   parameter int IW = 4
) (
   input  logic        [IW-1:0] idx,
   output logic signed [ZW-1:0] atan
);

   logic signed [ZW-1:0] tab [N];

   generate
      for (genvar i = 0; i < N; i++) begin : g_ent
         localparam int V = cordic_pkg::atan_code(i, ZW);
         assign tab[i] = ZW'(V);
      end
   endgenerate

   assign atan = tab[idx];

endmodule

// File: rtl/cordic_seq.sv
module cordic_seq #(
   parameter int N  = 16,
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          load,
   output logic          step,
   output logic          fin,
   output logic          busy,
   output logic [IW-1:0] iter
);
   import cordic_pkg::*;

   localparam logic [IW-1:0] LAST = IW'(N - 1);

   seq_state_e    st;
   logic [IW-1:0] cnt;

   assign load = start && (st == ST_IDLE);
   assign step = (st == ST_ROT);
   assign fin  = (st == ST_FIN);
   assign busy = (st != ST_IDLE);
   assign iter = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start) begin
                  st  <= ST_ROT;
                  cnt <= '0;
               end
            end
            ST_ROT: begin
               if (cnt == LAST) st <= ST_FIN;
               else             cnt <= cnt + 1'b1;
            end
            ST_FIN:  st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R8: a start during a run must not restart the count
   a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (start && step && cnt != LAST) |=> (step && cnt == $past(cnt) + 1'b1))
      else $error("start during run disturbed the iteration count");

   // R3: the final rotation is always followed by the output cycle
   a_r3_last_then_fin: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt == LAST) |=> fin)
      else $error("last iteration not followed by output cycle");

endmodule

// File: rtl/cordic_rot.sv
module cordic_rot #(
   parameter int W           = 16,
   parameter int G           = 3,
   parameter int N           = 16,
   parameter int IW          = 4,
   parameter int SHIFT_STYLE = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic                   step,
   input  logic                   fin,
   input  logic signed [W-1:0]    angle,
   input  logic        [IW-1:0]   iter,
   output logic signed [W+G-1:0]  x_o,
   output logic signed [W+G-1:0]  y_o
);
   localparam int DW = W + G;
   localparam logic signed [DW-1:0] X0   = DW'(cordic_pkg::inv_gain_code(N, DW));
   localparam logic signed [DW-1:0] ONE  = DW'(1) <<< (DW - 2);
   localparam logic signed [DW-1:0] ZLIM = DW'(cordic_pkg::atan_code(N - 1, DW) + N);
   localparam logic signed [DW-1:0] MLIM = ONE + DW'(2 * N);

   logic signed [DW-1:0] x_q, y_q, z_q;
   logic signed [DW-1:0] xs, ys, atan, z_init;
   logic                 z_neg;

   assign z_init = DW'(angle) <<< G;
   assign z_neg  = z_q[DW-1];

   cordic_atan_rom #(.N(N), .ZW(DW), .IW(IW)) u_rom (
      .idx  (iter),
      .atan (atan)
   );

   cordic_shift #(.DW(DW), .SW(IW), .STYLE(SHIFT_STYLE)) u_shx (
      .din  (x_q),
      .amt  (iter),
      .dout (xs)
   );

   cordic_shift #(.DW(DW), .SW(IW), .STYLE(SHIFT_STYLE)) u_shy (
      .din  (y_q),
      .amt  (iter),
      .dout (ys)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q <= '0;
         y_q <= '0;
         z_q <= '0;
      end else if (load) begin
         x_q <= X0;
         y_q <= '0;
         z_q <= z_init;
      end else if (step) begin
         if (z_neg) begin
            x_q <= x_q + ys;
            y_q <= y_q - xs;
            z_q <= z_q + atan;
         end else begin
            x_q <= x_q - ys;
            y_q <= y_q + xs;
            z_q <= z_q - atan;
         end
      end
   end

   assign x_o = x_q;
   assign y_o = y_q;

   // R4: residual angle has converged once all rotations are done
   a_r4_z_converged: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (z_q <= ZLIM && z_q >= -ZLIM))
      else $error("residual angle did not converge");

   // R4: the rotated vector stays on the unit circle
   a_r4_mag_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (x_q <= MLIM && x_q >= -MLIM && y_q <= MLIM && y_q >= -MLIM))
      else $error("rotated vector left the unit range");

endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos #(
   parameter int W           = 16,
   parameter int G           = 3,
   parameter int N           = 16,
   parameter int SHIFT_STYLE = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic signed [W-1:0] angle,
   output logic                busy,
   output logic                done,
   output logic signed [W-1:0] cos_out,
   output logic signed [W-1:0] sin_out
);
   localparam int DW = W + G;
   localparam int IW = (N > 1) ? $clog2(N) : 1;

   generate
      if (W < 8 || W > 24) begin : g_bad_w
         $error("W must lie in 8..24");
      end
      if (G < 0 || G > 6) begin : g_bad_g
         $error("G must lie in 0..6");
      end
      if (N < 4 || N > DW) begin : g_bad_n
         $error("N must lie in 4..W+G");
      end
      if (SHIFT_STYLE != 0 && SHIFT_STYLE != 1) begin : g_bad_s
         $error("SHIFT_STYLE must be 0 or 1");
      end
   endgenerate

   logic                 load, step, fin;
   logic [IW-1:0]        iter;
   logic signed [DW-1:0] xf, yf;
   logic signed [W-1:0]  c_rnd, s_rnd;
   logic                 done_q;
   logic signed [W-1:0]  cos_q, sin_q;

   cordic_seq #(.N(N), .IW(IW)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .step  (step),
      .fin   (fin),
      .busy  (busy),
      .iter  (iter)
   );

   cordic_rot #(.W(W), .G(G), .N(N), .IW(IW), .SHIFT_STYLE(SHIFT_STYLE)) u_rot (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .step  (step),
      .fin   (fin),
      .angle (angle),
      .iter  (iter),
      .x_o   (xf),
      .y_o   (yf)
   );

   generate
      if (G > 0) begin : g_round
         localparam logic signed [DW:0] HALF = (DW+1)'(1) <<< (G - 1);
         logic signed [DW:0] cx, sy;
         assign cx    = (DW+1)'(xf) + HALF;
         assign sy    = (DW+1)'(yf) + HALF;
         assign c_rnd = W'(cx >>> G);
         assign s_rnd = W'(sy >>> G);
      end else begin : g_plain
         assign c_rnd = W'(xf);
         assign s_rnd = W'(yf);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         cos_q  <= '0;
         sin_q  <= '0;
      end else begin
         done_q <= fin;
         if (fin) begin
            cos_q <= c_rnd;
            sin_q <= s_rnd;
         end
      end
   end

   assign done    = done_q;
   assign cos_out = cos_q;
   assign sin_out = sin_q;

   // R3: done is a single-cycle pulse
   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done longer than one cycle");

   // R3: done never overlaps busy
   a_r3_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy)
      else $error("done while busy");

   // R2: an idle start is accepted
   a_r2_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy)
      else $error("idle start not accepted");

   // R9: results move only with done
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(cos_out) && $stable(sin_out)))
      else $error("result changed outside done cycle");

endmodule

// File: tb/sim_cordic_sincos.sv
module sim_cordic_sincos;

   localparam int  W    = 16;
   localparam int  G    = 3;
   localparam int  N    = 16;
   localparam real PI_B = 3.14159265358979323846;
   localparam int  TOL  = 4;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start = 1'b0;
   logic signed [W-1:0] angle = '0;
   logic                busy, done;
   logic signed [W-1:0] cos_out, sin_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int last_c = 0;
   int last_s = 0;

   always #10 clk = ~clk;

   cordic_sincos #(.W(W), .G(G), .N(N), .SHIFT_STYLE(0)) u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .angle   (angle),
      .busy    (busy),
      .done    (done),
      .cos_out (cos_out),
      .sin_out (sin_out)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         errors++;
         $display("FAIL R3 watchdog expired actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int ideal(input int a, input bit want_sin);
      real th, v;
      th = real'(a) * PI_B / 32768.0;
      v  = want_sin ? $sin(th) : $cos(th);
      return $rtoi($floor(v * 16384.0 + 0.5));
   endfunction

   function automatic bit near(input int act, input int exp);
      return (act - exp <= TOL) && (exp - act <= TOL);
   endfunction

   // one request; returns at the negedge in which done is seen
   task automatic run_angle(input int a, input int mid, input int other, input string req);
      int cnt, ec, es;
      start = 1'b1;
      angle = W'(a);
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
      chk(cos_out == W'(last_c), "R9 cos held at start", int'(cos_out), last_c);
      chk(sin_out == W'(last_s), "R9 sin held at start", int'(sin_out), last_s);
      cnt = 0;
      while (!done && cnt < 200) begin
         if (mid > 0 && cnt == mid) begin
            start = 1'b1;
            angle = W'(other);
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         cnt++;
      end
      start = 1'b0;
      ec = ideal(a, 1'b0);
      es = ideal(a, 1'b1);
      chk(cnt == N + 1, {"R3 latency ", req}, cnt, N + 1);
      chk(busy == 1'b0, "R3 busy low with done", int'(busy), 0);
      chk(near(int'(cos_out), ec), {req, " cos"}, int'(cos_out), ec);
      chk(near(int'(sin_out), es), {req, " sin"}, int'(sin_out), es);
      last_c = int'(cos_out);
      last_s = int'(sin_out);
   endtask

   task automatic after_done();
      @(negedge clk);
      chk(done == 1'b0, "R3 done single cycle", int'(done), 0);
      repeat (4) @(negedge clk);
      chk(cos_out == W'(last_c), "R9 cos held idle", int'(cos_out), last_c);
      chk(sin_out == W'(last_s), "R9 sin held idle", int'(sin_out), last_s);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
      chk(done == 1'b0, "R1 done in reset", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cos_out == '0, "R1 cos after reset", int'(cos_out), 0);
      chk(sin_out == '0, "R1 sin after reset", int'(sin_out), 0);
      chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
   endtask

   task automatic t_zero();
      run_angle(0, 0, 0, "R5 zero");
      chk(near(int'(cos_out), 16384), "R5 cos unity", int'(cos_out), 16384);
      after_done();
   endtask

   task automatic t_positive();
      run_angle(5461, 0, 0, "R4 pi/6");
      after_done();
      run_angle(8192, 0, 0, "R4 pi/4");
      after_done();
      run_angle(10923, 0, 0, "R4 pi/3");
      after_done();
      run_angle(16384, 0, 0, "R4 pi/2");
      after_done();
      run_angle(1, 0, 0, "R4 tiny");
      after_done();
      run_angle(12345, 0, 0, "R4 odd");
      after_done();
   endtask

   task automatic t_negative();
      int pc, ps;
      run_angle(7000, 0, 0, "R6 mirror ref");
      pc = last_c;
      ps = last_s;
      after_done();
      run_angle(-7000, 0, 0, "R6 neg");
      chk(near(int'(cos_out), pc), "R6 cos even", int'(cos_out), pc);
      chk(near(int'(sin_out), -ps), "R6 sin odd", int'(sin_out), -ps);
      after_done();
      run_angle(-16384, 0, 0, "R6 -pi/2");
      after_done();
   endtask

   task automatic t_edges();
      run_angle(18100, 0, 0, "R7 upper edge");
      chk(cos_out < 0, "R7 cos negative", int'(cos_out), ideal(18100, 1'b0));
      after_done();
      run_angle(-18100, 0, 0, "R7 lower edge");
      after_done();
   endtask

   task automatic t_busy_start();
      run_angle(10923, 5, -12000, "R8 start ignored");
      after_done();
   endtask

   task automatic t_back_to_back();
      run_angle(4000, 0, 0, "R10 first");
      run_angle(-9000, 0, 0, "R10 second");
      after_done();
   endtask

   initial begin
      t_reset();
      t_zero();
      t_positive();
      t_negative();
      t_edges();
      t_busy_start();
      t_back_to_back();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule